// File: doc/BRIEF.md
# Receive Byte Queue with Bus Throttle

This block buffers data bytes arriving from a serial-bus byte receiver until a host removes them. It holds up to sixteen bytes in arrival order. Any byte that the receiver marks as an address byte is discarded and never takes a slot. The host reads the oldest byte from a show-ahead output and pops it with a one-cycle strobe.

A programmable 4-bit compare value sets an occupancy interrupt. The interrupt fires once the queue holds at least the compare value plus one bytes. A second interrupt flags a full queue. While the queue is full, a throttle output tells the bus engine to stall the bus until the host pops a byte.

Both interrupt flags are sticky. A flag's clear request only takes effect once the condition behind that flag has gone. Pushes that arrive while the queue is full are lost, and pops from an empty queue return zero. Each of these events latches its own error flag.

Top module: `rx_throttle_fifo`

## Requirements
- R1: Accepted data bytes leave in arrival order. `host_data` shows the oldest stored byte, and `level` reports the occupancy, from 0 to 16.
- R2: `irq_thresh` is set on the cycle after `level` is at least the compare value plus one. A compare value of 0 therefore flags the first byte.
- R3: `throttle` is high exactly while the queue holds 16 bytes.
- R4: A single pop from a full queue drops `throttle` on the next cycle.
- R5: `irq_full` is set on the cycle after the queue is full. `clr_full` leaves it set while the queue is still full and clears it on the next cycle once the queue is no longer full.
- R6: A byte presented with `byte_is_addr` high is not stored and leaves `level` unchanged.
- R7: A data byte offered while the queue is full is dropped and sets `overflow`. The byte is dropped even if a pop happens in the same cycle.
- R8: A pop while the queue is empty changes nothing in the queue and sets `underflow`. `host_data` reads 0 whenever the queue is empty.
- R9: A compare value written with `thr_we` is used from the next cycle on. `clr_thresh` clears `irq_thresh` only when the occupancy is below the threshold. `clr_err` clears `overflow` and `underflow`, and a new error in the same cycle keeps its flag set.
- R10: After reset the queue is empty, the compare value is 0, and every flag and `throttle` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| byte_valid | input | 1 | Receiver offers a byte this cycle |
| byte_is_addr | input | 1 | Offered byte is an address byte and is to be discarded |
| byte_data | input | 8 | Offered byte |
| host_pop | input | 1 | Host removes the oldest byte |
| host_data | output | 8 | Oldest stored byte, or 0 when empty |
| thr_we | input | 1 | Load a new compare value |
| thr_value | input | 4 | Compare value for the occupancy interrupt |
| clr_thresh | input | 1 | Clear request for the occupancy interrupt |
| clr_full | input | 1 | Clear request for the full interrupt |
| clr_err | input | 1 | Clear request for the overflow and underflow flags |
| level | output | 5 | Number of stored bytes |
| throttle | output | 1 | Bus engine must stall the bus |
| irq_thresh | output | 1 | Sticky occupancy interrupt |
| irq_full | output | 1 | Sticky full interrupt |
| overflow | output | 1 | Sticky flag: a byte was dropped |
| underflow | output | 1 | Sticky flag: a pop found the queue empty |

## Verification
On every cycle, the assertions check the following: the threshold and full flags rise after their conditions hold, one pop from a full queue releases the throttle, address bytes leave the occupancy unchanged, and pushing into a full queue or popping an empty one latches the matching error flag. Some behaviour only the bench scenarios can show. These cases are byte ordering across pointer wrap, a clear request being refused while the queue is full and accepted once it is not, and a new compare value taking effect a cycle late. The bench runs them against a queue-based reference model compared on every clock.

// File: rtl/rx_throttle_fifo.sv
module rx_throttle_fifo #(
  parameter int DW    = 8,
  parameter int DEPTH = 16
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         byte_valid,
  input  logic                         byte_is_addr,
  input  logic [DW-1:0]                byte_data,
  input  logic                         host_pop,
  output logic [DW-1:0]                host_data,
  input  logic                         thr_we,
  input  logic [$clog2(DEPTH)-1:0]     thr_value,
  input  logic                         clr_thresh,
  input  logic                         clr_full,
  input  logic                         clr_err,
  output logic [$clog2(DEPTH+1)-1:0]   level,
  output logic                         throttle,
  output logic                         irq_thresh,
  output logic                         irq_full,
  output logic                         overflow,
  output logic                         underflow
);
  localparam int AW = $clog2(DEPTH);
  localparam int CW = $clog2(DEPTH+1);

  logic [DW-1:0] mem [DEPTH];
  logic [AW-1:0] wptr, rptr, thr_q;
  logic [CW-1:0] count;
  logic          full, empty, push_req, do_push, do_pop, thr_hit;

  assign full     = (count == CW'(DEPTH));
  assign empty    = (count == '0);
  assign push_req = byte_valid & ~byte_is_addr;
  assign do_push  = push_req & ~full;
  assign do_pop   = host_pop & ~empty;
  assign thr_hit  = (count >= (CW'(thr_q) + CW'(1)));

  assign host_data = empty ? '0 : mem[rptr];
  assign level     = count;
  assign throttle  = full;

  always_ff @(posedge clk)
    if (do_push) mem[wptr] <= byte_data;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wptr  <= '0;
      rptr  <= '0;
      count <= '0;
    end else begin
      if (do_push) wptr <= (wptr == AW'(DEPTH-1)) ? '0 : wptr + AW'(1);
      if (do_pop)  rptr <= (rptr == AW'(DEPTH-1)) ? '0 : rptr + AW'(1);
      case ({do_push, do_pop})
        2'b10:   count <= count + CW'(1);
        2'b01:   count <= count - CW'(1);
        default: count <= count;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      thr_q      <= '0;
      irq_thresh <= 1'b0;
      irq_full   <= 1'b0;
      overflow   <= 1'b0;
      underflow  <= 1'b0;
    end else begin
      if (thr_we) thr_q <= thr_value;
      irq_thresh <= thr_hit | (irq_thresh & ~clr_thresh);
      irq_full   <= full    | (irq_full   & ~clr_full);
      overflow   <= (push_req & full)  | (overflow  & ~clr_err);
      underflow  <= (host_pop & empty) | (underflow & ~clr_err);
    end
  end

  p_thresh_sets_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (level >= (CW'(thr_q) + CW'(1))) |=> irq_thresh);

  p_pop_releases_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (throttle && host_pop) |=> !throttle);

  p_full_flag_r5: assert property (@(posedge clk) disable iff (!rst_n)
    throttle |=> irq_full);

  p_addr_dropped_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (byte_valid && byte_is_addr && !host_pop) |=> $stable(level));

  p_no_overflow_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (throttle && byte_valid && !byte_is_addr && !host_pop) |=> (overflow && throttle));

  p_underflow_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (level == '0 && host_pop) |=> underflow);

  p_level_bound_r1: assert property (@(posedge clk) disable iff (!rst_n)
    level <= CW'(DEPTH));
endmodule

// File: tb/test_rx_throttle_fifo.sv
module test_rx_throttle_fifo;
  logic clk = 0, rst_n = 0;
  logic byte_valid = 0, byte_is_addr = 0, host_pop = 0;
  logic [7:0] byte_data = 0;
  logic thr_we = 0, clr_thresh = 0, clr_full = 0, clr_err = 0;
  logic [3:0] thr_value = 0;
  logic [7:0] host_data;
  logic [4:0] level;
  logic throttle, irq_thresh, irq_full, overflow, underflow;

  int checks = 0, errors = 0;
  bit started = 0;

  always #5 clk = ~clk;

  rx_throttle_fifo i_rx_throttle_fifo (.*);

  logic [7:0] q[$];
  int  m_thr = 0;
  bit  m_ft = 0, m_ff = 0, m_ov = 0, m_un = 0;

  always @(posedge clk) begin
    if (!rst_n) begin
      q.delete(); m_thr = 0; m_ft = 0; m_ff = 0; m_ov = 0; m_un = 0;
    end else begin
      int n;
      bit nov, nun;
      n   = q.size();
      nov = 0; nun = 0;
      m_ft = (n >= m_thr + 1) || (m_ft && !clr_thresh);
      m_ff = (n == 16) || (m_ff && !clr_full);
      if (host_pop) begin
        if (n == 0) nun = 1; else void'(q.pop_front());
      end
      if (byte_valid && !byte_is_addr) begin
        if (n == 16) nov = 1; else q.push_back(byte_data);
      end
      m_ov = nov || (m_ov && !clr_err);
      m_un = nun || (m_un && !clr_err);
      if (thr_we) m_thr = thr_value;
    end
  end

  task automatic check(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, exp, $time);
    end
  endtask

  always @(negedge clk) if (started) begin
    check("R1 level", level, q.size());
    check("R1/R8 host_data", host_data, q.size() ? q[0] : 0);
    check("R3 throttle", throttle, q.size() == 16);
    check("R2 irq_thresh", irq_thresh, m_ft);
    check("R5 irq_full", irq_full, m_ff);
    check("R7 overflow", overflow, m_ov);
    check("R8 underflow", underflow, m_un);
  end

  task automatic idle();
    byte_valid = 0; byte_is_addr = 0; host_pop = 0;
    thr_we = 0; clr_thresh = 0; clr_full = 0; clr_err = 0;
  endtask

  task automatic step(); @(negedge clk); idle(); endtask

  task automatic push(input logic [7:0] d, input bit addr = 0);
    byte_valid = 1; byte_is_addr = addr; byte_data = d; step();
  endtask

  task automatic pop(); host_pop = 1; step(); endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [7:0] lf = 8'h5a;
    idle();
    repeat (3) @(negedge clk);
    rst_n = 1; started = 1;
    check("R10 level", level, 0);
    check("R10 throttle", throttle, 0);
    check("R10 flags", {irq_thresh, irq_full, overflow, underflow}, 0);
    step();
    check("R10 thr zero keeps irq low when empty", irq_thresh, 0);

    thr_value = 3; thr_we = 1; step();
    push(8'h11); push(8'h22);
    push(8'hA0, 1);
    check("R6 address byte not stored", level, 2);
    push(8'h33); push(8'h44);
    check("R2 not yet at next edge", irq_thresh, 0);
    step();
    check("R2 flag after 4 bytes", irq_thresh, 1);

    for (int i = 0; i < 12; i++) begin
      push(8'h50 + 8'(i));
      if (i == 5) push(8'hA1, 1);
    end
    check("R3 throttle at 16", throttle, 1);
    step();
    clr_full = 1; step();
    check("R5 clear refused while full", irq_full, 1);
    push(8'hEE);
    check("R7 overflow set", overflow, 1);
    check("R7 level held", level, 16);
    byte_valid = 1; byte_data = 8'hEF; host_pop = 1; step();
    check("R7 push with pop into full dropped", level, 15);
    push(8'h70);
    pop();
    check("R4 throttle released", throttle, 0);
    clr_full = 1; step();
    check("R5 clear accepted once not full", irq_full, 0);
    clr_err = 1; step();
    check("R9 clr_err clears overflow", overflow, 0);

    for (int i = 0; i < 5; i++) begin
      byte_valid = 1; byte_data = 8'h80 + 8'(i); host_pop = 1; step();
    end
    while (level != 0) pop();
    check("R8 empty reads zero", host_data, 0);
    pop();
    check("R8 underflow", underflow, 1);
    check("R8 level stays 0", level, 0);

    push(8'h91); push(8'h92);
    thr_value = 5; thr_we = 1; step();
    clr_thresh = 1; step();
    check("R9 thresh cleared below threshold", irq_thresh, 0);
    thr_value = 1; thr_we = 1; step();
    check("R9 new value not yet applied", irq_thresh, 0);
    step();
    check("R9 new value applied next cycle", irq_thresh, 1);
    clr_thresh = 1; step();
    check("R9 clear refused while above threshold", irq_thresh, 1);

    for (int i = 0; i < 600; i++) begin
      lf = {lf[6:0], lf[7] ^ lf[5] ^ lf[4] ^ lf[3]};
      byte_valid   = lf[0] | lf[1];
      byte_is_addr = lf[2] & lf[3];
      byte_data    = lf ^ 8'(i);
      host_pop     = lf[4] & (lf[5] | (i[7:6] == 2'b01));
      thr_we       = (lf[7:5] == 3'b101);
      thr_value    = lf[3:0];
      clr_thresh   = lf[6];
      clr_full     = lf[1] & lf[6];
      clr_err      = (lf[7:4] == 4'hF);
      @(negedge clk);
    end
    idle();
    step();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule